// File: doc/BRIEF.md
# Write-Back Data Cache with Maintenance Commands

This block is a small set-associative data cache between a processor load/store port and a single-word memory port. Reads that miss allocate a whole line; writes that hit only update the cached copy and mark it dirty. Writes that miss bypass the cache and go straight to memory. A dirty line reaches memory only when it is chosen as a victim or when software cleans it explicitly.

Software controls the cache through a small command port. One command sets the enable bit. One drops a single line, one cleans a single line, and one drops every line at once. The top eighth of the address space is decoded inside the block and reads as zeros without any memory cycle. Software can read one cache capacity of that window at line stride to push every dirty line out, and then drop everything safely.

The processor and command ports stall by holding their ready signal low until the access or command completes. Default geometry: 4 ways, 64 sets, 8 words per line (8 KB).

Top module: `wb_dcache`

## Requirements
- R1: After reset the cache is disabled and holds no valid line: a read goes to memory as one single-word request, and repeating it goes to memory again.
- R2: When enabled, a read miss fills the whole line with LINE_WORDS word reads at ascending line addresses; later reads anywhere in that line are served with no memory request.
- R3: When disabled, a read miss is served by one single-word memory read and allocates nothing. Read hits still return cached data, and write hits still update the cached word without any memory write.
- R4: A write hit updates the cached word, marks the line dirty and makes no memory request.
- R5: A write miss writes exactly one word to memory and allocates nothing, whether the cache is enabled or not.
- R6: Each set picks its victim by round robin over its ways, advanced on every fill. A dirty victim is written back as LINE_WORDS word writes, all completed before the first refill read.
- R7: Addresses with bits [31:29] = 3'b111 never produce a memory request. Reads there return zero and allocate when enabled. Write misses there are dropped, and write-backs of such lines make no memory request.
- R8: A command is a write on the command port with ctl_sel selecting the action: 0 = load the enable bit from ctl_wdata[0], 1 = invalidate the line holding address ctl_wdata, 2 = clean that line, 3 = invalidate all lines. ctl_ready marks completion.
- R9: Invalidate-line drops a resident line, dirty or not, without writing it back. On a miss it does nothing.
- R10: Clean-line on a dirty resident line writes it back with LINE_WORDS word writes and leaves it valid and clean. On a clean or absent line it makes no memory request.
- R11: Invalidate-all drops every line without write-back. Dirty data survives only if it was written back first, for example by a read sweep over the zero window.
- R12: cpu_ready is high only while a request is pending. A memory request is held, with a stable address and direction, until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access pending; held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| ctl_wr | input | 1 | Command pending; held until ctl_ready |
| ctl_sel | input | 2 | Command select (see R8) |
| ctl_wdata | input | 32 | Enable value or target address |
| ctl_ready | output | 1 | Command completes this cycle |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory beat completes |

## Verification
The bench builds the cache with 4 sets instead of 64, keeping 4 ways and 8-word lines, for a capacity of 16 lines. With this geometry, five addresses 128 bytes apart land in one set. That makes round-robin wrap and dirty-victim eviction reachable in a few accesses. A full displacement sweep over the zero window also needs only 16 reads, so the bench can run both the surviving and the lost dirty-data cases within a short run.

// File: rtl/wbdc_pkg.sv
package wbdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_SREAD,
    ST_SWRITE
  } wbdc_st_e;

  typedef enum logic [1:0] {
    CMD_ENABLE    = 2'd0,
    CMD_INV_LINE  = 2'd1,
    CMD_CLEAN     = 2'd2,
    CMD_INV_ALL   = 2'd3
  } wbdc_cmd_e;

  localparam logic [2:0] ZERO_WINDOW = 3'b111;

  function automatic logic in_zero_window(input logic [31:0] a);
    return a[31:29] == ZERO_WINDOW;
  endfunction

endpackage

// File: rtl/wbdc_tags.sv
module wbdc_tags #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  lk_idx,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic                     hit,
  output logic [$clog2(WAYS)-1:0]  hit_way,
  output logic [WAYS-1:0]          lk_valid,
  output logic [WAYS-1:0]          lk_dirty,
  input  logic [$clog2(WAYS)-1:0]  rd_way,
  output logic [TAG_W-1:0]         rd_tag,
  input  logic [$clog2(SETS)-1:0]  wr_idx,
  input  logic [$clog2(WAYS)-1:0]  wr_way,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic                     do_fill,
  input  logic                     do_clr_valid,
  input  logic                     do_set_dirty,
  input  logic                     do_clr_dirty,
  input  logic                     do_inv_all
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  dty_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  way_hit;

  assign lk_valid = vld_q[lk_idx];
  assign lk_dirty = dty_q[lk_idx];
  assign rd_tag   = tag_q[lk_idx][rd_way];

  // one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  assign hit = |way_hit;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
      end
    end else if (do_inv_all) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
      end
    end else begin
      if (do_fill) begin
        vld_q[wr_idx][wr_way] <= 1'b1;
        dty_q[wr_idx][wr_way] <= 1'b0;
      end
      if (do_clr_valid) begin
        vld_q[wr_idx][wr_way] <= 1'b0;
        dty_q[wr_idx][wr_way] <= 1'b0;
      end
      if (do_set_dirty) dty_q[wr_idx][wr_way] <= 1'b1;
      if (do_clr_dirty) dty_q[wr_idx][wr_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) tag_q[wr_idx][wr_way] <= wr_tag;
  end

endmodule

// File: rtl/wbdc_data.sv
module wbdc_data #(
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 8
) (
  input  logic                          clk,
  input  logic [$clog2(WAYS)-1:0]       way,
  input  logic [$clog2(SETS)-1:0]       idx,
  input  logic [$clog2(LINE_WORDS)-1:0] word,
  input  logic                          we,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata
);
  localparam int DEPTH = WAYS * SETS * LINE_WORDS;
  localparam int AW    = $clog2(DEPTH);

  logic [31:0]   words_q [DEPTH];
  logic [AW-1:0] ptr;

  assign ptr   = {way, idx, word};
  assign rdata = words_q[ptr];

  always_ff @(posedge clk) begin
    if (we) words_q[ptr] <= wdata;
  end

endmodule

// File: rtl/wbdc_rr.sv
module wbdc_rr #(
  parameter int SETS = 64,
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] rd_idx,
  output logic [$clog2(WAYS)-1:0] victim,
  input  logic                    adv,
  input  logic [$clog2(SETS)-1:0] adv_idx
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] ptr_q [SETS];

  assign victim = ptr_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv) begin
      ptr_q[adv_idx] <= ptr_q[adv_idx] + WAY_W'(1);
    end
  end

endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
  import wbdc_pkg::*;
#(
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_ready,
  input  logic        ctl_wr,
  input  logic [1:0]  ctl_sel,
  input  logic [31:0] ctl_wdata,
  output logic        ctl_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int TAG_W = 32 - IDX_W - OFF_W - 2;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // state
  wbdc_st_e         st_q, st_d;
  logic [OFF_W-1:0] beat_q, beat_d;
  logic [WAY_W-1:0] way_q, way_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [TAG_W-1:0] wbtag_q, wbtag_d;
  logic [TAG_W-1:0] ftag_q, ftag_d;
  logic             chain_q, chain_d;
  logic             en_q, en_d;

  // lookup address: a pending command wins over a processor access
  logic [31:0]      lk_addr;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [OFF_W-1:0] lk_word;
  logic             lk_zero;

  assign lk_addr = ctl_wr ? ctl_wdata : cpu_addr;
  assign lk_idx  = lk_addr[IDX_W+OFF_W+1 -: IDX_W];
  assign lk_tag  = lk_addr[31 -: TAG_W];
  assign lk_word = lk_addr[OFF_W+1 -: OFF_W];
  assign lk_zero = in_zero_window(lk_addr);

  // sub-block wiring
  logic             hit;
  logic [WAY_W-1:0] hit_way, vic_way;
  logic [WAYS-1:0]  lk_valid, lk_dirty;
  logic [TAG_W-1:0] vic_tag;
  logic [IDX_W-1:0] t_idx;
  logic [WAY_W-1:0] t_way;
  logic             t_fill, t_clr_v, t_set_d, t_clr_d, t_inv_all;
  logic [WAY_W-1:0] d_way;
  logic [IDX_W-1:0] d_idx;
  logic [OFF_W-1:0] d_word;
  logic             d_we;
  logic [31:0]      d_wdata, d_rdata;
  logic             rr_adv;

  wbdc_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_i),
    .lk_idx(lk_idx), .lk_tag(lk_tag),
    .hit(hit), .hit_way(hit_way), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .rd_way(vic_way), .rd_tag(vic_tag),
    .wr_idx(t_idx), .wr_way(t_way), .wr_tag(ftag_q),
    .do_fill(t_fill), .do_clr_valid(t_clr_v), .do_set_dirty(t_set_d),
    .do_clr_dirty(t_clr_d), .do_inv_all(t_inv_all)
  );

  wbdc_data #(.SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk(clk), .way(d_way), .idx(d_idx), .word(d_word),
    .we(d_we), .wdata(d_wdata), .rdata(d_rdata)
  );

  wbdc_rr #(.SETS(SETS), .WAYS(WAYS)) u_rr (
    .clk(clk), .rst_n(rst_i), .rd_idx(lk_idx), .victim(vic_way),
    .adv(rr_adv), .adv_idx(idx_q)
  );

  // array addressing: the lookup result when idle, latched line otherwise
  logic idle;
  assign idle   = (st_q == ST_IDLE);
  assign t_idx  = idle ? lk_idx  : idx_q;
  assign t_way  = idle ? hit_way : way_q;
  assign d_idx  = idle ? lk_idx  : idx_q;
  assign d_way  = idle ? hit_way : way_q;
  assign d_word = idle ? lk_word : beat_q;

  logic [31:0] wb_addr, fill_addr;
  assign wb_addr   = {wbtag_q, idx_q, beat_q, 2'b00};
  assign fill_addr = {ftag_q, idx_q, beat_q, 2'b00};

  logic beat_done;

  always_comb begin
    st_d      = st_q;
    beat_d    = beat_q;
    way_d     = way_q;
    idx_d     = idx_q;
    wbtag_d   = wbtag_q;
    ftag_d    = ftag_q;
    chain_d   = chain_q;
    en_d      = en_q;
    cpu_ready = 1'b0;
    cpu_rdata = '0;
    ctl_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    t_fill    = 1'b0;
    t_clr_v   = 1'b0;
    t_set_d   = 1'b0;
    t_clr_d   = 1'b0;
    t_inv_all = 1'b0;
    d_we      = 1'b0;
    d_wdata   = cpu_wdata;
    rr_adv    = 1'b0;
    beat_done = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (ctl_wr) begin
          unique case (wbdc_cmd_e'(ctl_sel))
            CMD_ENABLE: begin
              en_d      = ctl_wdata[0];
              ctl_ready = 1'b1;
            end
            CMD_INV_ALL: begin
              t_inv_all = 1'b1;
              ctl_ready = 1'b1;
            end
            CMD_INV_LINE: begin
              t_clr_v   = hit;
              ctl_ready = 1'b1;
            end
            CMD_CLEAN: begin
              if (hit && lk_dirty[hit_way]) begin
                way_d   = hit_way;
                idx_d   = lk_idx;
                wbtag_d = lk_tag;
                chain_d = 1'b0;
                beat_d  = '0;
                st_d    = ST_WB;
              end else begin
                ctl_ready = 1'b1;
              end
            end
            default: ctl_ready = 1'b1;
          endcase
        end else if (cpu_req) begin
          if (cpu_we) begin
            if (hit) begin
              d_we      = 1'b1;
              t_set_d   = 1'b1;
              cpu_ready = 1'b1;
            end else if (lk_zero) begin
              cpu_ready = 1'b1;
            end else begin
              st_d = ST_SWRITE;
            end
          end else if (hit) begin
            cpu_rdata = d_rdata;
            cpu_ready = 1'b1;
          end else if (en_q) begin
            way_d   = vic_way;
            idx_d   = lk_idx;
            wbtag_d = vic_tag;
            ftag_d  = lk_tag;
            chain_d = 1'b1;
            beat_d  = '0;
            st_d    = (lk_valid[vic_way] && lk_dirty[vic_way]) ? ST_WB : ST_FILL;
          end else if (lk_zero) begin
            cpu_ready = 1'b1;
          end else begin
            st_d = ST_SREAD;
          end
        end
      end

      ST_WB: begin
        if (in_zero_window(wb_addr)) begin
          beat_done = 1'b1;
        end else begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = wb_addr;
          mem_wdata = d_rdata;
          beat_done = mem_ack;
        end
        if (beat_done) begin
          beat_d = beat_q + OFF_W'(1);
          if (beat_q == LAST_BEAT) begin
            t_clr_d = 1'b1;
            beat_d  = '0;
            st_d    = chain_q ? ST_FILL : ST_IDLE;
          end
        end
      end

      ST_FILL: begin
        if (in_zero_window(fill_addr)) begin
          d_wdata   = '0;
          beat_done = 1'b1;
        end else begin
          mem_req   = 1'b1;
          mem_addr  = fill_addr;
          d_wdata   = mem_rdata;
          beat_done = mem_ack;
        end
        d_we = beat_done;
        if (beat_done) begin
          beat_d = beat_q + OFF_W'(1);
          if (beat_q == LAST_BEAT) begin
            t_fill = 1'b1;
            rr_adv = 1'b1;
            beat_d = '0;
            st_d   = ST_IDLE;
          end
        end
      end

      ST_SREAD: begin
        mem_req  = 1'b1;
        mem_addr = {cpu_addr[31:2], 2'b00};
        if (mem_ack) begin
          cpu_rdata = mem_rdata;
          cpu_ready = 1'b1;
          st_d      = ST_IDLE;
        end
      end

      ST_SWRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {cpu_addr[31:2], 2'b00};
        mem_wdata = cpu_wdata;
        if (mem_ack) begin
          cpu_ready = 1'b1;
          st_d      = ST_IDLE;
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      way_q   <= '0;
      idx_q   <= '0;
      wbtag_q <= '0;
      ftag_q  <= '0;
      chain_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      beat_q  <= beat_d;
      way_q   <= way_d;
      idx_q   <= idx_d;
      wbtag_q <= wbtag_d;
      ftag_q  <= ftag_d;
      chain_q <= chain_d;
      en_q    <= en_d;
    end
  end

endmodule

// File: rtl/wbdc_checker.sv
module wbdc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic [31:0] cpu_addr,
  input logic        cpu_ready,
  input logic        ctl_wr,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        en_q
);

  AST_ZERO_WINDOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[31:29] != 3'b111)); // R7

  AST_READY_ONLY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req); // R12

  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12

  AST_DISABLED_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && cpu_req && !cpu_we && !ctl_wr && mem_req && !mem_we)
      |-> (mem_addr[31:2] == cpu_addr[31:2])); // R3

  AST_WRITE_MISS_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !ctl_wr && mem_req)
      |-> (mem_we && mem_addr[31:2] == cpu_addr[31:2])); // R5

endmodule

bind wb_dcache wbdc_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
  .ctl_wr(ctl_wr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .en_q(en_q)
);

// File: tb/sim_wb_dcache.sv
module sim_wb_dcache;
  localparam int SETS       = 4;
  localparam int WAYS       = 4;
  localparam int LINE_WORDS = 8;
  localparam int LINES      = SETS * WAYS;
  localparam int LINE_BYTES = LINE_WORDS * 4;

  logic        clk;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_ready;
  logic        ctl_wr;
  logic [1:0]  ctl_sel;
  logic [31:0] ctl_wdata;
  logic        ctl_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;

  wb_dcache #(.SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata), .ctl_ready(ctl_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  // behavioural memory: one ack per beat, one cycle after the request is seen
  logic [31:0] mem [4096];
  int rd_cnt, wr_cnt, w2r_cnt;
  logic last_wr;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= pat(32'(i) << 2);
      mem_ack <= 1'b0; mem_rdata <= '0;
      rd_cnt <= 0; wr_cnt <= 0; w2r_cnt <= 0; last_wr <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        last_wr <= 1'b1;
      end else begin
        mem_rdata <= mem[mem_addr[13:2]];
        rd_cnt <= rd_cnt + 1;
        if (last_wr) w2r_cnt <= w2r_cnt + 1;
        last_wr <= 1'b0;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  int n_chk, n_err;
  int rd0, wr0, tr0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mark;
    rd0 = rd_cnt; wr0 = wr_cnt; tr0 = w2r_cnt;
  endtask

  task automatic chk_traffic(input string tag, input int er, input int ew);
    chk({tag, " mem reads"},  32'(rd_cnt - rd0), 32'(er));
    chk({tag, " mem writes"}, 32'(wr_cnt - wr0), 32'(ew));
  endtask

  task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] q, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0;
    #1;
    while (!cpu_ready && cyc < 2000) begin
      @(negedge clk); #1; cyc++;
    end
    q = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic ctl_op(input logic [1:0] sel, input logic [31:0] d);
    int cyc;
    @(negedge clk);
    ctl_wr = 1'b1; ctl_sel = sel; ctl_wdata = d;
    cyc = 0;
    #1;
    while (!ctl_ready && cyc < 2000) begin
      @(negedge clk); #1; cyc++;
    end
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp,
                        input int er, input int ew);
    logic [31:0] q; int cyc;
    mark();
    cpu_op(1'b0, a, '0, q, cyc);
    chk({tag, " data"}, q, exp);
    chk_traffic(tag, er, ew);
  endtask

  task automatic wr_chk(input string tag, input logic [31:0] a, input logic [31:0] d,
                        input int er, input int ew);
    logic [31:0] q; int cyc;
    mark();
    cpu_op(1'b1, a, d, q, cyc);
    chk_traffic(tag, er, ew);
  endtask

  // table: we, addr, wdata, expected read data, expected reads, expected writes
  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [7:0]  nrd;
    logic [7:0]  nwr;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 32'h0000_0100, 32'h0,          32'h5B5A_0100, 8'd8, 8'd0, 8'd2}, // R2 miss fills line
    '{1'b0, 32'h0000_011C, 32'h0,          32'h5B46_011C, 8'd0, 8'd0, 8'd2}, // R2 hit, last word
    '{1'b1, 32'h0000_0104, 32'hDEAD_0001,  32'h0,         8'd0, 8'd0, 8'd4}, // R4 write hit
    '{1'b0, 32'h0000_0104, 32'h0,          32'hDEAD_0001, 8'd0, 8'd0, 8'd4}, // R4 read back
    '{1'b1, 32'h0000_0800, 32'h1234_5678,  32'h0,         8'd0, 8'd1, 8'd5}, // R5 write miss
    '{1'b0, 32'h0000_0800, 32'h0,          32'h1234_5678, 8'd8, 8'd0, 8'd5}, // R5 not allocated
    '{1'b0, 32'hE000_0040, 32'h0,          32'h0,         8'd0, 8'd0, 8'd7}, // R7 zero fill
    '{1'b0, 32'hE000_0044, 32'h0,          32'h0,         8'd0, 8'd0, 8'd7}  // R7 zero hit
  };

  initial begin
    n_err = 0;
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] q;
    int cyc;
    n_chk = 0;
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    ctl_wr = 1'b0; ctl_sel = '0; ctl_wdata = '0;
    repeat (4) @(negedge clk);
    chk("R1 ready low in reset", {31'b0, cpu_ready}, 32'd0);
    chk("R1 no mem request in reset", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: disabled and empty after reset
    rd_chk("R1 first read", 32'h200, pat(32'h200), 1, 0);
    rd_chk("R1 repeat read", 32'h200, pat(32'h200), 1, 0);

    ctl_op(2'd0, 32'd1); // R8 enable

    for (int i = 0; i < 8; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VEC[i].req, i);
      mark();
      cpu_op(VEC[i].we, VEC[i].addr, VEC[i].wdata, q, cyc);
      if (!VEC[i].we) chk({tg, " data"}, q, VEC[i].exp);
      chk_traffic(tg, int'(VEC[i].nrd), int'(VEC[i].nwr));
    end

    // R6: one set, round robin and dirty victim
    rd_chk("R6 fill 060", 32'h060, pat(32'h060), 8, 0);
    wr_chk("R4 dirty 060", 32'h060, 32'hBEEF_0060, 0, 0);
    mark();
    cpu_op(1'b0, 32'h0E0, '0, q, cyc);
    chk("R12 stall during fill", {31'b0, (cyc >= 2 * LINE_WORDS)}, 32'd1);
    rd_chk("R6 fill 160", 32'h160, pat(32'h160), 8, 0);
    rd_chk("R6 fill 1E0", 32'h1E0, pat(32'h1E0), 8, 0);
    mark();
    rd_chk("R6 evict dirty", 32'h260, pat(32'h260), 8, 8);
    chk("R6 writeback before refill", 32'(w2r_cnt - tr0), 32'd1);
    chk("R6 victim data in memory", mem[32'h060 >> 2], 32'hBEEF_0060);
    rd_chk("R6 next victim way1", 32'h060, 32'hBEEF_0060, 8, 0);
    rd_chk("R6 next victim way2", 32'h0E0, pat(32'h0E0), 8, 0);

    // R3: disabled behaviour
    ctl_op(2'd0, 32'd0);
    rd_chk("R3 hit while disabled", 32'h260, pat(32'h260), 0, 0);
    rd_chk("R3 miss single read", 32'h3000, pat(32'h3000), 1, 0);
    rd_chk("R3 miss not allocated", 32'h3000, pat(32'h3000), 1, 0);
    wr_chk("R3 write hit updates", 32'h264, 32'hCAFE_0264, 0, 0);
    rd_chk("R3 write hit read back", 32'h264, 32'hCAFE_0264, 0, 0);
    wr_chk("R5 write miss disabled", 32'h3004, 32'h5555_3004, 0, 1);
    chk("R5 word in memory", mem[32'h3004 >> 2], 32'h5555_3004);
    rd_chk("R7 zero read disabled", 32'hE000_0100, 32'h0, 0, 0);

    // R10: clean one line
    mark(); ctl_op(2'd2, 32'h264);
    chk_traffic("R10 clean dirty", 0, LINE_WORDS);
    chk("R10 cleaned word", mem[32'h264 >> 2], 32'hCAFE_0264);
    mark(); ctl_op(2'd2, 32'h264);
    chk_traffic("R10 clean twice", 0, 0);
    mark(); ctl_op(2'd2, 32'h3000);
    chk_traffic("R10 clean absent", 0, 0);
    rd_chk("R10 line stays valid", 32'h264, 32'hCAFE_0264, 0, 0);

    // R9: invalidate one line drops dirty data
    wr_chk("R9 dirty 260", 32'h260, 32'h1111_0260, 0, 0);
    mark(); ctl_op(2'd1, 32'h260);
    chk_traffic("R9 invalidate no writeback", 0, 0);
    rd_chk("R9 line gone", 32'h260, pat(32'h260), 1, 0);

    // R11: sweep of the zero window saves dirty data
    ctl_op(2'd0, 32'd1);
    wr_chk("R11 dirty 108", 32'h108, 32'h7777_0108, 0, 0);
    mark();
    for (int k = 0; k < LINES; k++) begin
      cpu_op(1'b0, 32'hE000_0000 + 32'(k * LINE_BYTES), '0, q, cyc);
      chk("R7 sweep reads zero", q, 32'h0);
    end
    chk_traffic("R11 sweep pushes dirty line", 0, LINE_WORDS);
    chk("R11 swept word 108", mem[32'h108 >> 2], 32'h7777_0108);
    chk("R11 swept word 104", mem[32'h104 >> 2], 32'hDEAD_0001);
    mark(); ctl_op(2'd3, 32'h0);
    chk_traffic("R11 invalidate all silent", 0, 0);
    rd_chk("R11 survived", 32'h108, 32'h7777_0108, 8, 0);

    // R11: without the sweep the dirty word is lost
    wr_chk("R11 dirty again", 32'h108, 32'h9999_0108, 0, 0);
    ctl_op(2'd3, 32'h0);
    rd_chk("R11 lost without sweep", 32'h108, 32'h7777_0108, 8, 0);

    // R7: write miss to the zero window is dropped
    wr_chk("R7 zero write miss", 32'hE000_1000, 32'hFFFF_FFFF, 0, 0);
    rd_chk("R7 zero read after drop", 32'hE000_1000, 32'h0, 0, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule